// File: doc/BRIEF.md
# CCM Init and Header Phase Sequencer

This block is the control side of a block-cipher engine working in counter-with-CBC-MAC chaining. Software programs a control word (enable, algorithm mode, phase, key length), loads the key and nonce words while the engine is stopped, and then streams 32-bit data words into an eight-entry input queue. The sequencer packs every four queued words into one 128-bit block. It hands that block to an external cipher datapath through a request/acknowledge pair and keeps only one block outstanding at a time.

The sequencer covers the first two stages of a message. In the init stage exactly one 128-bit block is taken, and the enable bit drops by itself once that block has been acknowledged. The associated-data stage is optional and may only follow a completed init stage, before any payload stage has started. In both stages results returned by the cipher are not shown on the data-out port. Any attempt to start a stage out of order is refused and latched in a sticky error flag.

Top module: `ccm_phase_seq`

## Requirements
- R1: After reset, enable, mode, phase, key length and error flags are 0 and the queue is empty. A control write while enable is 0 loads mode, phase and enable. While enable is 1, a control write only acts when its enable field is 0, which clears enable. Mode, phase and key length then keep their values.
- R2: Key and nonce word writes while enable is 1 are ignored. Key word n drives `blk_key` bits [255-32n -: 32], and nonce word n drives `blk_iv` bits [127-32n -: 32].
- R3: Mode 5'b01001 selects CCM chaining. The phase codes are 2'b00 init, 2'b01 associated data, 2'b10 payload and 2'b11 final. In any other mode, phase 2'b00 neither restricts input nor clears enable.
- R4: In the CCM init stage only four words are accepted per enable. After the fourth word `fifo_nf` is 0, and further words are dropped.
- R5: When the cipher acknowledges the init block, enable clears in the same cycle that `blk_req` falls.
- R6: Enabling CCM with phase 2'b01 before a completed init stage or after a payload stage, or with phase 2'b10 or 2'b11 before a completed init stage, leaves enable at 0 and sets `seq_err`. The flag stays set until reset. Going straight from init to payload is allowed.
- R7: A request is issued only once four words are queued. A partial group of one to three words raises no request.
- R8: The first word written in a group forms bits [127:96] of `blk_data`, and the fourth word forms bits [31:0].
- R9: `blk_req` and `busy` stay high, with `blk_data` unchanged, from the request until the cycle in which `blk_ack` is seen. The next group is requested no earlier than the following cycle.
- R10: `fifo_nf` is 1 while fewer than eight words are queued, and `fifo_empty` is 1 when none are queued. Words offered while `fifo_nf` is 0 are lost.
- R11: In CCM init and associated-data stages `dout_valid` stays 0. In other stages an acknowledgement gives a one-cycle `dout_valid` on the next cycle, with `dout_data` equal to bits [127:96] of `blk_rsp`.
- R12: Key length codes 2'b00, 2'b01 and 2'b10 select 128, 192 and 256 bits. A control write carrying 2'b11 keeps the previous key length.
- R13: Clearing enable empties the queue by the next cycle. A block already requested stays requested until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_en | input | 1 | Enable field of the control write |
| ctl_mode | input | 5 | Algorithm mode field |
| ctl_phase | input | 2 | Phase field |
| ctl_klen | input | 2 | Key length field |
| key_we | input | 1 | Key word write strobe |
| key_idx | input | 3 | Key word index |
| iv_we | input | 1 | Nonce word write strobe |
| iv_idx | input | 2 | Nonce word index |
| cfg_wdata | input | 32 | Data for key and nonce word writes |
| din_we | input | 1 | Input word strobe |
| din_data | input | 32 | Input word |
| fifo_nf | output | 1 | Input queue can take a word |
| fifo_empty | output | 1 | Input queue holds no word |
| busy | output | 1 | A block is waiting for acknowledgement |
| seq_err | output | 1 | Sticky stage ordering error |
| cfg_en | output | 1 | Current enable bit |
| cfg_mode | output | 5 | Current algorithm mode |
| cfg_phase | output | 2 | Current phase |
| cfg_klen | output | 2 | Current key length code |
| blk_req | output | 1 | Block request to the cipher |
| blk_data | output | 128 | Block sent to the cipher |
| blk_key | output | 256 | Key words to the cipher |
| blk_iv | output | 128 | Nonce words to the cipher |
| blk_ack | input | 1 | Cipher acknowledges the block |
| blk_rsp | input | 128 | Cipher result for the acknowledged block |
| dout_valid | output | 1 | Data-out word valid |
| dout_data | output | 32 | Data-out word |

## Verification
The packing path is tried with an init stream that overruns its four-word limit, which separates the init word cap from the general queue-full rule. A three-word partial group followed by a tail shows that grouping waits for the fourth word, and a 13-word stream against a slow acknowledge fills the queue, so the full flag, dropped words, held requests and word order can be told apart. Payload and non-CCM runs show that the stage gates output rather than the handshake itself. Out-of-order stage selections, before and after a reset, separate the refusal of enable from the sticky flag.

// File: rtl/ccm_phase_seq.sv
module ccm_phase_seq #(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int KEY_WORDS  = 8,
  parameter int IV_WORDS   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctl_we,
  input  logic                        ctl_en,
  input  logic [4:0]                  ctl_mode,
  input  logic [1:0]                  ctl_phase,
  input  logic [1:0]                  ctl_klen,
  input  logic                        key_we,
  input  logic [$clog2(KEY_WORDS)-1:0] key_idx,
  input  logic                        iv_we,
  input  logic [$clog2(IV_WORDS)-1:0] iv_idx,
  input  logic [WORD_W-1:0]           cfg_wdata,
  input  logic                        din_we,
  input  logic [WORD_W-1:0]           din_data,
  output logic                        fifo_nf,
  output logic                        fifo_empty,
  output logic                        busy,
  output logic                        seq_err,
  output logic                        cfg_en,
  output logic [4:0]                  cfg_mode,
  output logic [1:0]                  cfg_phase,
  output logic [1:0]                  cfg_klen,
  output logic                        blk_req,
  output logic [4*WORD_W-1:0]         blk_data,
  output logic [KEY_WORDS*WORD_W-1:0] blk_key,
  output logic [IV_WORDS*WORD_W-1:0]  blk_iv,
  input  logic                        blk_ack,
  input  logic [4*WORD_W-1:0]         blk_rsp,
  output logic                        dout_valid,
  output logic [WORD_W-1:0]           dout_data
);

  localparam int BLK_WORDS = 4;
  localparam int BLK_W     = BLK_WORDS * WORD_W;
  localparam int AW        = $clog2(FIFO_DEPTH);
  localparam int CW        = $clog2(FIFO_DEPTH + 1);
  localparam int ICW       = $clog2(BLK_WORDS + 1);
  localparam logic [CW-1:0]  DEPTH_C = CW'(FIFO_DEPTH);
  localparam logic [CW-1:0]  GRP_C   = CW'(BLK_WORDS);
  localparam logic [ICW-1:0] ICAP_C  = ICW'(BLK_WORDS);
  localparam logic [4:0] MODE_CCM = 5'b01001;
  localparam logic [1:0] PH_INIT  = 2'b00;
  localparam logic [1:0] PH_HDR   = 2'b01;
  localparam logic [1:0] KLEN_RSV = 2'b11;

  logic              en_q, idone_q, pseen_q, err_q;
  logic [4:0]        mode_q;
  logic [1:0]        phase_q, klen_q;
  logic [WORD_W-1:0] fifo_mem [FIFO_DEPTH];
  logic [WORD_W-1:0] key_mem  [KEY_WORDS];
  logic [WORD_W-1:0] iv_mem   [IV_WORDS];
  logic [AW-1:0]     rd_q, wr_q;
  logic [CW-1:0]     cnt_q;
  logic [ICW-1:0]    icnt_q;
  logic              busy_q, dv_q;
  logic [BLK_W-1:0]  blk_q, gathered;
  logic [WORD_W-1:0] dout_q;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= FIFO_DEPTH) s = s - FIFO_DEPTH;
    return AW'(s);
  endfunction

  wire is_ccm   = (mode_q == MODE_CCM);
  wire init_ph  = is_ccm && (phase_q == PH_INIT);
  wire quiet    = is_ccm && (phase_q == PH_INIT || phase_q == PH_HDR);
  wire nf       = (cnt_q < DEPTH_C) && !(init_ph && icnt_q == ICAP_C);
  wire push     = din_we && en_q && nf;
  wire issue    = en_q && !busy_q && (cnt_q >= GRP_C);
  wire ack      = busy_q && blk_ack;
  wire init_fin = ack && init_ph && en_q;
  wire arm      = ctl_we && !en_q && ctl_en;
  wire new_ccm  = (ctl_mode == MODE_CCM);
  wire bad      = arm && new_ccm &&
                  ((ctl_phase == PH_HDR && (!idone_q || pseen_q)) ||
                   (ctl_phase[1] && !idone_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= '0;
      phase_q <= '0;
      klen_q  <= '0;
      idone_q <= 1'b0;
      pseen_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (!en_q) begin
        if (ctl_we) begin
          mode_q  <= ctl_mode;
          phase_q <= ctl_phase;
          if (ctl_klen != KLEN_RSV) klen_q <= ctl_klen;
          en_q    <= ctl_en && !bad;
        end
      end else if (init_fin || (ctl_we && !ctl_en)) begin
        en_q <= 1'b0;
      end
      if (bad) err_q <= 1'b1;
      if (arm && !bad && new_ccm) begin
        if (ctl_phase == PH_INIT) begin
          idone_q <= 1'b0;
          pseen_q <= 1'b0;
        end else if (ctl_phase[1]) begin
          pseen_q <= 1'b1;
        end
      end
      if (init_fin) idone_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEY_WORDS; i++) key_mem[i] <= '0;
      for (int i = 0; i < IV_WORDS; i++) iv_mem[i] <= '0;
    end else if (!en_q) begin
      if (key_we) key_mem[key_idx] <= cfg_wdata;
      if (iv_we) iv_mem[iv_idx] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo_mem[wr_q] <= din_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      icnt_q <= '0;
    end else if (!en_q) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      icnt_q <= '0;
    end else begin
      if (push) wr_q <= adv(wr_q, 1);
      if (issue) rd_q <= adv(rd_q, BLK_WORDS);
      cnt_q <= cnt_q + CW'(push) - (issue ? GRP_C : '0);
      if (push && init_ph) icnt_q <= icnt_q + 1'b1;
    end
  end

  always_comb begin
    gathered = '0;
    for (int i = 0; i < BLK_WORDS; i++)
      gathered[BLK_W-1-i*WORD_W -: WORD_W] = fifo_mem[adv(rd_q, i)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      blk_q  <= '0;
      dv_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      if (issue) begin
        busy_q <= 1'b1;
        blk_q  <= gathered;
      end else if (ack) begin
        busy_q <= 1'b0;
      end
      dv_q <= ack && !quiet;
      if (ack && !quiet) dout_q <= blk_rsp[BLK_W-1 -: WORD_W];
    end
  end

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
    assign blk_key[KEY_WORDS*WORD_W-1-g*WORD_W -: WORD_W] = key_mem[g];
  end
  for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
    assign blk_iv[IV_WORDS*WORD_W-1-g*WORD_W -: WORD_W] = iv_mem[g];
  end

  assign fifo_nf    = nf;
  assign fifo_empty = (cnt_q == '0);
  assign busy       = busy_q;
  assign blk_req    = busy_q;
  assign blk_data   = blk_q;
  assign seq_err    = err_q;
  assign cfg_en     = en_q;
  assign cfg_mode   = mode_q;
  assign cfg_phase  = phase_q;
  assign cfg_klen   = klen_q;
  assign dout_valid = dv_q;
  assign dout_data  = dout_q;

  // R1
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && $past(en_q) |-> $stable(mode_q) && $stable(phase_q) && $stable(klen_q));
  // R4
  init_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_ph && en_q |-> icnt_q <= ICAP_C);
  // R5
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_fin |=> !en_q);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R7
  grp_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cnt_q) >= GRP_C);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req && !blk_ack |=> blk_req && $stable(blk_data));
  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);
  // R11
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && en_q && $past(en_q) |-> !dout_valid);

endmodule

// File: tb/ccm_phase_seq_test.sv
module ccm_phase_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_en = 0, key_we = 0, iv_we = 0, din_we = 0, blk_ack = 0;
  logic [4:0] ctl_mode = '0;
  logic [1:0] ctl_phase = '0, ctl_klen = '0, iv_idx = '0;
  logic [2:0] key_idx = '0;
  logic [31:0] cfg_wdata = '0, din_data = '0;
  logic [127:0] blk_rsp = '0;
  logic fifo_nf, fifo_empty, busy, seq_err, cfg_en, blk_req, dout_valid;
  logic [4:0] cfg_mode;
  logic [1:0] cfg_phase, cfg_klen;
  logic [127:0] blk_data, blk_iv;
  logic [255:0] blk_key;
  logic [31:0] dout_data;

  localparam logic [127:0] MASK = 128'h5A5A_0F0F_C3C3_9696_1234_5678_9ABC_DEF0;

  ccm_phase_seq uut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0, ack_delay = 2, ack_cnt = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference model
  bit m_en, m_idone, m_pseen, m_err, m_busy, m_dv;
  bit [4:0] m_mode;
  bit [1:0] m_ph, m_kl;
  int m_icnt;
  logic [31:0] m_q[$];
  logic [127:0] m_blk;
  logic [31:0] m_dout;
  logic [31:0] m_key[8], m_iv[4];

  function automatic bit m_nf();
    return (m_q.size() < 8) && !(m_mode == 5'b01001 && m_ph == 2'b00 && m_icnt == 4);
  endfunction

  always @(posedge clk) begin
    bit ccm, initph, quiet, push, issue, ack, ifin, arm, nccm, bad, pre_en;
    if (!rst_n) begin
      m_en = 0; m_idone = 0; m_pseen = 0; m_err = 0; m_busy = 0; m_dv = 0;
      m_mode = 0; m_ph = 0; m_kl = 0; m_icnt = 0; m_q.delete();
      m_blk = '0; m_dout = '0;
      foreach (m_key[i]) m_key[i] = '0;
      foreach (m_iv[i]) m_iv[i] = '0;
    end else begin
      ccm = (m_mode == 5'b01001);
      initph = ccm && m_ph == 2'b00;
      quiet = ccm && m_ph < 2;
      push = din_we && m_en && m_nf();
      issue = m_en && !m_busy && m_q.size() >= 4;
      ack = m_busy && blk_ack;
      ifin = ack && initph && m_en;
      arm = ctl_we && !m_en && ctl_en;
      nccm = (ctl_mode == 5'b01001);
      bad = arm && nccm && ((ctl_phase == 2'b01 && (!m_idone || m_pseen)) ||
                            (ctl_phase >= 2 && !m_idone));
      pre_en = m_en;
      if (!pre_en) begin
        if (ctl_we) begin
          m_mode = ctl_mode; m_ph = ctl_phase;
          if (ctl_klen != 2'b11) m_kl = ctl_klen;
          m_en = ctl_en && !bad;
        end
        if (key_we) m_key[key_idx] = cfg_wdata;
        if (iv_we) m_iv[iv_idx] = cfg_wdata;
      end else if (ifin || (ctl_we && !ctl_en)) m_en = 0;
      if (bad) m_err = 1;
      if (arm && !bad && nccm) begin
        if (ctl_phase == 0) begin m_idone = 0; m_pseen = 0; end
        else if (ctl_phase >= 2) m_pseen = 1;
      end
      if (ifin) m_idone = 1;
      if (!pre_en) begin
        m_q.delete(); m_icnt = 0;
      end else begin
        if (issue) begin
          m_blk = {m_q[0], m_q[1], m_q[2], m_q[3]};
          repeat (4) void'(m_q.pop_front());
        end
        if (push) begin
          m_q.push_back(din_data);
          if (initph) m_icnt++;
        end
      end
      if (issue) m_busy = 1; else if (ack) m_busy = 0;
      m_dv = ack && !quiet;
      if (m_dv) m_dout = blk_rsp[127:96];
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [255:0] k;
      logic [127:0] v;
      for (int i = 0; i < 8; i++) k[255-32*i -: 32] = m_key[i];
      for (int i = 0; i < 4; i++) v[127-32*i -: 32] = m_iv[i];
      chk(cfg_en == m_en, "R1 R5 enable", cfg_en, m_en);
      chk(cfg_mode == m_mode && cfg_phase == m_ph, "R1 R3 mode/phase", {cfg_mode, cfg_phase}, {m_mode, m_ph});
      chk(cfg_klen == m_kl, "R12 key length", cfg_klen, m_kl);
      chk(seq_err == m_err, "R6 seq_err", seq_err, m_err);
      chk(fifo_nf == m_nf(), "R4 R10 fifo_nf", fifo_nf, m_nf());
      chk(fifo_empty == (m_q.size() == 0), "R10 R13 fifo_empty", fifo_empty, m_q.size() == 0);
      chk(blk_req == m_busy && busy == m_busy, "R9 blk_req/busy", {busy, blk_req}, {m_busy, m_busy});
      if (m_busy) chk(blk_data == m_blk, "R8 blk_data", blk_data, m_blk);
      chk(dout_valid == m_dv, "R11 dout_valid", dout_valid, m_dv);
      if (m_dv) chk(dout_data == m_dout, "R11 dout_data", dout_data, m_dout);
      chk(blk_key == k && blk_iv == v, "R2 key/iv", {blk_key[127:0], blk_iv}, {k[127:0], v});
    end
  end

  // cipher stub
  always @(negedge clk) begin
    if (!rst_n) begin blk_ack <= 0; ack_cnt <= 0; end
    else if (blk_ack) begin blk_ack <= 0; ack_cnt <= 0; end
    else if (blk_req) begin
      if (ack_cnt >= ack_delay) begin blk_ack <= 1; blk_rsp <= blk_data ^ MASK; end
      else ack_cnt <= ack_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic ctl_wr(input bit en, input logic [4:0] md, input logic [1:0] ph, input logic [1:0] kl);
    ctl_we = 1; ctl_en = en; ctl_mode = md; ctl_phase = ph; ctl_klen = kl;
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic put(input logic [31:0] w);
    din_we = 1; din_data = w;
    @(negedge clk); din_we = 0;
  endtask
  task automatic key_wr(input int i, input logic [31:0] w);
    key_we = 1; key_idx = 3'(i); cfg_wdata = w;
    @(negedge clk); key_we = 0;
  endtask
  task automatic wait_req(input bit lvl);
    for (int i = 0; i < 100 && blk_req != lvl; i++) @(negedge clk);
  endtask
  task automatic wait_dv();
    for (int i = 0; i < 100 && !dout_valid; i++) @(negedge clk);
  endtask
  task automatic do_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  initial begin
    do_reset();
    cmp_on = 1;
    chk(cfg_en == 0 && fifo_empty == 1 && seq_err == 0 && blk_req == 0, "R1 reset state",
        {cfg_en, fifo_empty, seq_err, blk_req}, 4'b0100);
    for (int i = 0; i < 8; i++) key_wr(i, 32'hA0A0_0000 + i);
    iv_we = 1; iv_idx = 2'd3; cfg_wdata = 32'hCAFE_0003; @(negedge clk); iv_we = 0;
    chk(blk_key[255:224] == 32'hA0A0_0000 && blk_iv[31:0] == 32'hCAFE_0003, "R2 word placement",
        {blk_key[255:224], blk_iv[31:0]}, {32'hA0A0_0000, 32'hCAFE_0003});
    ctl_wr(1, 5'b01001, 2'b00, 2'b10);
    ctl_wr(1, 5'b00000, 2'b01, 2'b00);
    chk(cfg_mode == 5'b01001 && cfg_phase == 0 && cfg_klen == 2'b10 && cfg_en, "R1 locked fields",
        {cfg_en, cfg_mode, cfg_phase, cfg_klen}, {1'b1, 5'b01001, 2'b00, 2'b10});
    key_wr(0, 32'hDEAD_BEEF);
    chk(blk_key[255:224] == 32'hA0A0_0000, "R2 key write while enabled", blk_key[255:224], 32'hA0A0_0000);
    ack_delay = 3;
    for (int i = 0; i < 4; i++) put(32'h1111_0000 + i);
    chk(fifo_nf == 0, "R4 init cap", fifo_nf, 0);
    put(32'h1111_0004); put(32'h1111_0005);
    wait_req(1);
    chk(blk_data == {32'h1111_0000, 32'h1111_0001, 32'h1111_0002, 32'h1111_0003}, "R8 init block order",
        blk_data, {32'h1111_0000, 32'h1111_0001, 32'h1111_0002, 32'h1111_0003});
    wait_req(0);
    chk(cfg_en == 0 && dout_valid == 0, "R5 self clear", {cfg_en, dout_valid}, 2'b00);

    ctl_wr(1, 5'b01001, 2'b01, 2'b10);
    chk(cfg_en == 1 && seq_err == 0, "R6 header after init", {cfg_en, seq_err}, 2'b10);
    ack_delay = 6;
    for (int i = 0; i < 3; i++) put(32'h2222_0000 + i);
    repeat (4) @(negedge clk);
    chk(blk_req == 0 && fifo_empty == 0, "R7 partial group", {blk_req, fifo_empty}, 2'b00);
    for (int i = 3; i < 8; i++) put(32'h2222_0000 + i);
    wait_req(1);
    chk(blk_data[127:96] == 32'h2222_0000, "R8 header first word", blk_data[127:96], 32'h2222_0000);
    repeat (3) @(negedge clk);
    chk(blk_req == 1 && blk_data[31:0] == 32'h2222_0003, "R9 held request", {blk_req, blk_data[31:0]}, {1'b1, 32'h2222_0003});
    wait_req(0); @(negedge clk);
    wait_req(1);
    chk(blk_data[127:96] == 32'h2222_0004, "R9 second group", blk_data[127:96], 32'h2222_0004);
    wait_req(0);
    chk(dout_valid == 0 && cfg_en == 1, "R11 header quiet", {dout_valid, cfg_en}, 2'b01);

    ack_delay = 20;
    chk(fifo_empty == 1, "R10 empty before burst", fifo_empty, 1);
    for (int i = 0; i < 12; i++) put(32'h3333_0000 + i);
    chk(fifo_nf == 0, "R10 full", fifo_nf, 0);
    put(32'h3333_00FF);
    wait_req(0); @(negedge clk); wait_req(1);
    chk(blk_data[127:96] == 32'h3333_0004, "R10 second block", blk_data[127:96], 32'h3333_0004);
    wait_req(0); @(negedge clk); wait_req(1);
    chk(blk_data[31:0] == 32'h3333_000B, "R10 dropped word", blk_data[31:0], 32'h3333_000B);
    wait_req(0);
    chk(fifo_empty == 1, "R10 drained", fifo_empty, 1);

    ack_delay = 2;
    put(32'h4444_0000); put(32'h4444_0001);
    ctl_wr(0, 5'b01001, 2'b01, 2'b10);
    @(negedge clk);
    chk(fifo_empty == 1 && cfg_en == 0, "R13 flush", {fifo_empty, cfg_en}, 2'b10);

    ctl_wr(1, 5'b01001, 2'b10, 2'b10);
    chk(cfg_en == 1 && seq_err == 0, "R6 payload after header", {cfg_en, seq_err}, 2'b10);
    for (int i = 0; i < 4; i++) put(32'h5555_0000 + i);
    wait_dv();
    chk(dout_valid == 1 && dout_data == (32'h5555_0000 ^ MASK[127:96]), "R11 payload output",
        {dout_valid, dout_data}, {1'b1, 32'h5555_0000 ^ MASK[127:96]});
    ctl_wr(0, 5'b01001, 2'b10, 2'b10);
    ctl_wr(1, 5'b01001, 2'b01, 2'b10);
    chk(seq_err == 1 && cfg_en == 0, "R6 header after payload", {seq_err, cfg_en}, 2'b10);
    ctl_wr(0, 5'b01001, 2'b00, 2'b11);
    chk(cfg_klen == 2'b10, "R12 reserved key length", cfg_klen, 2'b10);
    ctl_wr(0, 5'b01001, 2'b00, 2'b01);
    chk(cfg_klen == 2'b01, "R12 192-bit code", cfg_klen, 2'b01);

    ctl_wr(1, 5'b00000, 2'b00, 2'b00);
    for (int i = 0; i < 6; i++) put(32'h6666_0000 + i);
    wait_dv();
    chk(dout_valid == 1 && cfg_en == 1 && dout_data == (32'h6666_0000 ^ MASK[127:96]), "R3 non-CCM init",
        {dout_valid, cfg_en, dout_data}, {2'b11, 32'h6666_0000 ^ MASK[127:96]});
    wait_req(0);
    ctl_wr(0, 5'b00000, 2'b00, 2'b00);

    do_reset();
    chk(seq_err == 0 && cfg_klen == 0, "R1 second reset", {seq_err, cfg_klen}, 3'b000);
    ctl_wr(1, 5'b01001, 2'b01, 2'b00);
    chk(seq_err == 1 && cfg_en == 0, "R6 header without init", {seq_err, cfg_en}, 2'b10);
    ctl_wr(1, 5'b01001, 2'b00, 2'b00);
    chk(seq_err == 1 && cfg_en == 1, "R6 sticky after init start", {seq_err, cfg_en}, 2'b11);
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule